// File: doc/BRIEF.md
# Debug Register Access Scan Chain

This block sits behind a JTAG TAP controller and gives an external debugger read and write access to a bank of up to 128 registers of 32 bits each. The TAP supplies the instruction register value and the Capture-DR, Shift-DR and Update-DR strobes. The block decodes the instruction and picks one of three data registers. The first is a 40-bit access chain. The second is a 5-bit chain-select register. The third is a 1-bit bypass stage that is used for every other instruction.

Each access-chain scan carries a 32-bit data word, a 7-bit register address and a direction bit. On Update-DR the block issues one single-cycle access strobe to the register bank. Reads are pipelined across scans. The bank data is latched when the read strobe fires, and it is shifted out in the data field of the next access scan. A debugger therefore ends a burst of reads with one dummy read of register 0. That dummy read collects the last word without touching a register that advances when it is read.

Top module: `jtag_regacc_chain`

## Requirements
- R1: After reset, chainSel is 5'h1F and regWrite and regRead are low. The first access-chain scan shifts out a data field of zero.
- R2: The access chain is 40 bits long and shifts LSB first from tdi toward tdo. Bits 31:0 hold data, bits 38:32 hold the address and bit 39 is the direction bit. tdo always shows chain bit 0.
- R3: A chain with bit 39 = 1, under instruction 4'hC, produces a regWrite pulse exactly one cycle long in the cycle after Update-DR. During that pulse regAddr and regWrData hold the scanned address and data, and regRead stays low.
- R4: A chain with bit 39 = 0, under instruction 4'hC, produces a regRead pulse exactly one cycle long in the cycle after Update-DR, with regAddr holding the scanned address. The regRdData value present during that pulse is the data field shifted out by the next access-chain scan.
- R5: At Capture-DR the address field and the direction bit of the access chain load zero.
- R6: Only instruction 4'hC leads to bank accesses. An Update-DR under any other instruction produces neither strobe.
- R7: Instruction 4'h2 selects the 5-bit chain-select register. Capture-DR loads the current chainSel value, the register shifts LSB first, and Update-DR copies the shifted value to chainSel. chainSel changes at no other time.
- R8: Any instruction other than 4'hC and 4'h2 selects a 1-bit bypass stage. It captures 0, so tdo shows 0 first and then tdi delayed by one shift.
- R9: A write access leaves the latched read data unchanged. A read issues exactly one read strobe, so a register that advances on each read advances once per read request. A dummy read of register 0 advances no other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous reset, active low |
| irValue | input | 4 | Current instruction register contents |
| captureDr | input | 1 | TAP in Capture-DR this cycle |
| shiftDr | input | 1 | TAP in Shift-DR this cycle |
| updateDr | input | 1 | TAP in Update-DR this cycle |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out from the selected register |
| regAddr | output | 7 | Register bank address |
| regWrData | output | 32 | Register bank write data |
| regWrite | output | 1 | Single-cycle write strobe |
| regRead | output | 1 | Single-cycle read strobe |
| regRdData | input | 32 | Register bank read data, valid while regRead is high |
| chainSel | output | 5 | Chain-select register value |

## Verification
A wrong read latch shows up in the data field of the very next access scan. Because reads are pipelined, every check compares a scan's output against the request made one scan earlier. A wrong direction flag or strobe decode shows in the single cycle after Update-DR as a missing, extra or swapped strobe, and an extra strobe also moves the self-advancing register in the bench bank. A wrong bit order or an off-by-one field boundary corrupts the address or data seen at the bank within the same scan. Faults in the select or bypass paths show in the tdo sequence of the first scan under those instructions.

// File: rtl/jtag_regacc_pkg.sv
package jtag_regacc_pkg;

  // Per-cycle strobes from control to datapath, one group per data register.
  typedef struct packed {
    logic capAcc;
    logic shiftAcc;
    logic updAcc;
    logic capSel;
    logic shiftSel;
    logic updSel;
    logic capByp;
    logic shiftByp;
  } dpStrobes_t;

  typedef enum logic [1:0] {
    TDO_ACC = 2'd0,
    TDO_SEL = 2'd1,
    TDO_BYP = 2'd2
  } tdoSrc_t;

endpackage

// File: rtl/jtag_regacc_ctrl.sv
module jtag_regacc_ctrl
  import jtag_regacc_pkg::*;
#(
  parameter int IR_W = 4,
  parameter logic [IR_W-1:0] ACC_CODE = 4'hC,
  parameter logic [IR_W-1:0] SEL_CODE = 4'h2
) (
  input  logic            tck,
  input  logic            trstN,
  input  logic [IR_W-1:0] irValue,
  input  logic            captureDr,
  input  logic            shiftDr,
  input  logic            updateDr,
  output dpStrobes_t      stb,
  output tdoSrc_t         tdoSrc,
  output logic            accPulse
);

  logic isAcc;
  logic isSel;
  logic isByp;

  always_comb begin
    isAcc = (irValue == ACC_CODE);
    isSel = (irValue == SEL_CODE);
    isByp = !isAcc && !isSel;
  end

  always_comb begin
    stb.capAcc   = captureDr && isAcc;
    stb.shiftAcc = shiftDr && isAcc;
    stb.updAcc   = updateDr && isAcc;
    stb.capSel   = captureDr && isSel;
    stb.shiftSel = shiftDr && isSel;
    stb.updSel   = updateDr && isSel;
    stb.capByp   = captureDr && isByp;
    stb.shiftByp = shiftDr && isByp;
  end

  always_comb begin
    if (isAcc)      tdoSrc = TDO_ACC;
    else if (isSel) tdoSrc = TDO_SEL;
    else            tdoSrc = TDO_BYP;
  end

  // One access per Update-DR under the access instruction.
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) accPulse <= 1'b0;
    else        accPulse <= updateDr && isAcc;
  end

endmodule

// File: rtl/jtag_regacc_dp.sv
module jtag_regacc_dp
  import jtag_regacc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7,
  parameter int SEL_W  = 5
) (
  input  logic              tck,
  input  logic              trstN,
  input  dpStrobes_t        stb,
  input  tdoSrc_t           tdoSrc,
  input  logic              accPulse,
  input  logic              tdi,
  input  logic [DATA_W-1:0] regRdData,
  output logic              tdo,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWrite,
  output logic              regRead,
  output logic [SEL_W-1:0]  chainSel
);

  localparam int CHAIN_W = DATA_W + ADDR_W + 1;
  localparam int DIR_BIT = CHAIN_W - 1;

  logic [CHAIN_W-1:0] accSr;
  logic [DATA_W-1:0]  rdLatch;
  logic               pendWr;
  logic [SEL_W-1:0]   selSr;
  logic               bypReg;

  // Access chain: data field reloads with the last read word, the rest clears.
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)            accSr <= '0;
    else if (stb.capAcc)   accSr <= {{(ADDR_W + 1){1'b0}}, rdLatch};
    else if (stb.shiftAcc) accSr <= {tdi, accSr[CHAIN_W-1:1]};
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      regAddr   <= '0;
      regWrData <= '0;
      pendWr    <= 1'b0;
    end else if (stb.updAcc) begin
      regAddr   <= accSr[DATA_W +: ADDR_W];
      regWrData <= accSr[DATA_W-1:0];
      pendWr    <= accSr[DIR_BIT];
    end
  end

  always_comb begin
    regWrite = accPulse && pendWr;
    regRead  = accPulse && !pendWr;
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)       rdLatch <= '0;
    else if (regRead) rdLatch <= regRdData;
  end

  // Chain-select register with a shadow shift stage.
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)            selSr <= '1;
    else if (stb.capSel)   selSr <= chainSel;
    else if (stb.shiftSel) selSr <= {tdi, selSr[SEL_W-1:1]};
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)          chainSel <= '1;
    else if (stb.updSel) chainSel <= selSr;
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)            bypReg <= 1'b0;
    else if (stb.capByp)   bypReg <= 1'b0;
    else if (stb.shiftByp) bypReg <= tdi;
  end

  always_comb begin
    unique case (tdoSrc)
      TDO_ACC: tdo = accSr[0];
      TDO_SEL: tdo = selSr[0];
      default: tdo = bypReg;
    endcase
  end

endmodule

// File: rtl/jtag_regacc_chain.sv
module jtag_regacc_chain
  import jtag_regacc_pkg::*;
#(
  parameter int IR_W   = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7,
  parameter int SEL_W  = 5,
  parameter logic [IR_W-1:0] ACC_CODE = 4'hC,
  parameter logic [IR_W-1:0] SEL_CODE = 4'h2
) (
  input  logic              tck,
  input  logic              trstN,
  input  logic [IR_W-1:0]   irValue,
  input  logic              captureDr,
  input  logic              shiftDr,
  input  logic              updateDr,
  input  logic              tdi,
  output logic              tdo,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWrite,
  output logic              regRead,
  input  logic [DATA_W-1:0] regRdData,
  output logic [SEL_W-1:0]  chainSel
);

  dpStrobes_t stb;
  tdoSrc_t    tdoSrc;
  logic       accPulse;

  jtag_regacc_ctrl #(
    .IR_W(IR_W), .ACC_CODE(ACC_CODE), .SEL_CODE(SEL_CODE)
  ) u_ctrl (
    .tck(tck), .trstN(trstN), .irValue(irValue),
    .captureDr(captureDr), .shiftDr(shiftDr), .updateDr(updateDr),
    .stb(stb), .tdoSrc(tdoSrc), .accPulse(accPulse)
  );

  jtag_regacc_dp #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
  ) u_dp (
    .tck(tck), .trstN(trstN), .stb(stb), .tdoSrc(tdoSrc),
    .accPulse(accPulse), .tdi(tdi), .regRdData(regRdData),
    .tdo(tdo), .regAddr(regAddr), .regWrData(regWrData),
    .regWrite(regWrite), .regRead(regRead), .chainSel(chainSel)
  );

endmodule

// File: rtl/jtag_regacc_chain_chk.sv
module jtag_regacc_chain_chk #(
  parameter int IR_W  = 4,
  parameter int SEL_W = 5,
  parameter logic [IR_W-1:0] ACC_CODE = 4'hC,
  parameter logic [IR_W-1:0] SEL_CODE = 4'h2
) (
  input logic             tck,
  input logic             trstN,
  input logic [IR_W-1:0]  irValue,
  input logic             updateDr,
  input logic             regWrite,
  input logic             regRead,
  input logic [SEL_W-1:0] chainSel
);

  AST_STROBE_EXCL: assert property (@(posedge tck) disable iff (!trstN)
    !(regWrite && regRead)); // R3

  AST_WRITE_AFTER_UPDATE: assert property (@(posedge tck) disable iff (!trstN)
    regWrite |-> $past(updateDr && irValue == ACC_CODE)); // R3

  AST_READ_ONE_CYCLE: assert property (@(posedge tck) disable iff (!trstN)
    regRead |=> !regRead); // R4

  AST_NO_ACCESS_OTHER_IR: assert property (@(posedge tck) disable iff (!trstN)
    (updateDr && irValue != ACC_CODE) |=> !(regWrite || regRead)); // R6

  AST_SEL_HOLDS: assert property (@(posedge tck) disable iff (!trstN)
    !(updateDr && irValue == SEL_CODE) |=> $stable(chainSel)); // R7

endmodule

bind jtag_regacc_chain jtag_regacc_chain_chk #(
  .IR_W(IR_W), .SEL_W(SEL_W), .ACC_CODE(ACC_CODE), .SEL_CODE(SEL_CODE)
) u_chk (
  .tck(tck), .trstN(trstN), .irValue(irValue), .updateDr(updateDr),
  .regWrite(regWrite), .regRead(regRead), .chainSel(chainSel)
);

// File: tb/test_jtag_regacc_chain.sv
module test_jtag_regacc_chain;

  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] ADV_ADDR = 7'd5;

  logic        tck = 1'b0;
  logic        trstN = 1'b0;
  logic [3:0]  irValue = 4'hC;
  logic        captureDr = 1'b0, shiftDr = 1'b0, updateDr = 1'b0, tdi = 1'b0;
  logic        tdo;
  logic [6:0]  regAddr;
  logic [31:0] regWrData;
  logic        regWrite, regRead;
  logic [31:0] regRdData;
  logic [4:0]  chainSel;

  int checks = 0;
  int fails = 0;

  // Bench register bank: register 5 advances on every read.
  logic [31:0] mem [128];
  logic [31:0] advCnt;
  logic [31:0] expMem [128];

  assign regRdData = (regAddr == ADV_ADDR) ? advCnt : mem[regAddr];

  always @(posedge tck) begin
    if (regWrite) mem[regAddr] <= regWrData;
    if (regRead && regAddr == ADV_ADDR) advCnt <= advCnt + 1;
  end

  always #(CLK_PERIOD / 2) tck = ~tck;

  jtag_regacc_chain i_jtag_regacc_chain (
    .tck(tck), .trstN(trstN), .irValue(irValue),
    .captureDr(captureDr), .shiftDr(shiftDr), .updateDr(updateDr),
    .tdi(tdi), .tdo(tdo), .regAddr(regAddr), .regWrData(regWrData),
    .regWrite(regWrite), .regRead(regRead), .regRdData(regRdData),
    .chainSel(chainSel)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One DR scan of n bits; records the strobes in the cycle after Update-DR.
  task automatic scan(input int n, input logic [39:0] din, output logic [39:0] dout,
                      output logic sawWr, output logic sawRd,
                      output logic [6:0] a, output logic [31:0] d);
    dout = '0;
    captureDr = 1'b1;
    @(negedge tck);
    captureDr = 1'b0;
    shiftDr = 1'b1;
    for (int i = 0; i < n; i++) begin
      tdi = din[i];
      dout[i] = tdo;
      @(negedge tck);
    end
    shiftDr = 1'b0;
    updateDr = 1'b1;
    @(negedge tck);
    updateDr = 1'b0;
    sawWr = regWrite;
    sawRd = regRead;
    a = regAddr;
    d = regWrData;
    @(negedge tck);
    check(!regWrite && !regRead, "R3 strobe longer than one cycle", {regWrite, regRead}, 0);
  endtask

  function automatic logic [39:0] accWord(input logic wr, input logic [6:0] a, input logic [31:0] d);
    return {wr, a, d};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [39:0] dout;
    logic sw, sr;
    logic [6:0] a;
    logic [31:0] d;
    logic [31:0] expNext;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 128; i++) begin
      mem[i] = 32'hA000_0000 + i;
      expMem[i] = 32'hA000_0000 + i;
    end
    advCnt = 32'd100;
    repeat (3) @(negedge tck);
    // R1 reset state
    check(chainSel == 5'h1F, "R1 chainSel reset", chainSel, 5'h1F);
    check(!regWrite && !regRead, "R1 strobes idle", {regWrite, regRead}, 0);
    trstN = 1'b1;
    @(negedge tck);

    // R3 + R2 directed write
    irValue = 4'hC;
    scan(40, accWord(1'b1, 7'h2A, 32'hDEAD_BEEF), dout, sw, sr, a, d);
    expMem[7'h2A] = 32'hDEAD_BEEF;
    check(dout[31:0] == 0, "R1 first scan data zero", dout[31:0], 0);
    check(dout[39:32] == 0, "R5 addr/dir capture zero", dout[39:32], 0);
    check(sw && !sr, "R3 write strobe", {sw, sr}, 2'b10);
    check(a == 7'h2A, "R2 address field position", a, 7'h2A);
    check(d == 32'hDEAD_BEEF, "R2 data field order", d, 32'hDEAD_BEEF);

    // R4 read, pipelined result
    scan(40, accWord(1'b0, 7'h2A, 32'h0), dout, sw, sr, a, d);
    check(!sw && sr, "R4 read strobe", {sw, sr}, 2'b01);
    check(dout[31:0] == 0, "R9 write left latch unchanged", dout[31:0], 0);
    scan(40, accWord(1'b0, ADV_ADDR, 32'h0), dout, sw, sr, a, d);
    check(dout[31:0] == 32'hDEAD_BEEF, "R4 read data next scan", dout[31:0], 32'hDEAD_BEEF);
    // R9 auto-advance register read once, dummy read of 0 ends the burst
    scan(40, accWord(1'b0, 7'h0, 32'h0), dout, sw, sr, a, d);
    check(dout[31:0] == 32'd100, "R9 advancing register value", dout[31:0], 100);
    scan(40, accWord(1'b1, 7'h1, 32'h1111_2222), dout, sw, sr, a, d);
    expMem[1] = 32'h1111_2222;
    check(dout[31:0] == expMem[0], "R9 dummy read returns reg 0", dout[31:0], expMem[0]);
    check(advCnt == 32'd101, "R9 single advance", advCnt, 101);

    // Random mix
    expNext = expMem[0];
    for (int k = 0; k < 60; k++) begin
      logic wr;
      logic [6:0] ra;
      logic [31:0] rd;
      wr = 1'($urandom);
      ra = 7'($urandom);
      if (ra == ADV_ADDR) ra = 7'd6;
      rd = $urandom;
      scan(40, accWord(wr, ra, rd), dout, sw, sr, a, d);
      check(dout[31:0] == expNext, "R4 random pipelined data", dout[31:0], expNext);
      check(dout[39:32] == 0, "R5 random capture zero", dout[39:32], 0);
      check(sw == wr && sr == !wr && a == ra, "R3 random strobe/addr", {sw, sr, a}, {wr, !wr, ra});
      if (wr) begin
        check(d == rd, "R3 random write data", d, rd);
        expMem[ra] = rd;
      end else begin
        expNext = expMem[ra];
      end
    end

    // R7 chain-select register
    irValue = 4'h2;
    scan(5, 40'h0A, dout, sw, sr, a, d);
    check(dout[4:0] == 5'h1F, "R7 capture current select", dout[4:0], 5'h1F);
    check(chainSel == 5'h0A, "R7 select updated", chainSel, 5'h0A);
    check(!sw && !sr, "R6 no access under select IR", {sw, sr}, 0);
    scan(5, 40'h13, dout, sw, sr, a, d);
    check(dout[4:0] == 5'h0A, "R7 readback", dout[4:0], 5'h0A);
    check(chainSel == 5'h13, "R7 second update", chainSel, 5'h13);

    // R8 bypass
    irValue = 4'h7;
    scan(8, 40'hB5, dout, sw, sr, a, d);
    check(dout[7:0] == 8'h6A, "R8 bypass delay", dout[7:0], 8'h6A);
    check(!sw && !sr, "R6 no access under bypass", {sw, sr}, 0);
    check(chainSel == 5'h13, "R7 select held outside its IR", chainSel, 5'h13);

    // Access chain still delivers the pending word after other IRs
    irValue = 4'hC;
    scan(40, accWord(1'b0, 7'h0, 32'h0), dout, sw, sr, a, d);
    check(dout[31:0] == expNext, "R4 latch kept across IR change", dout[31:0], expNext);

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule